// File: doc/BRIEF.md
# Scalar Double-Precision Compare Flag Unit

This block takes two IEEE-754 binary64 values and reduces their relation to a three-bit condition code: zero, parity and carry. A less-than result raises carry alone. An equal result raises zero alone. A greater-than result leaves all three low. If either value is a NaN, the pair has no order and all three bits go high. The overflow, sign and auxiliary-carry outputs are tied low. The block also reports two status bits. Invalid-operation depends on the NaN rule of the selected mode. Denormal-operand is raised when either value is subnormal.

The inputs come in on a valid/ready handshake. Each transfer carries both operand words, the mode bit and one mask bit per exception. The operand words may be wider than 64 bits, and only the low 64 bits of each are compared. The result is registered and appears one cycle after acceptance. It comes with a flag write-enable, which is suppressed when a raised exception is not masked. In that case the condition bits keep their old values.

A two-state machine controls the unit. In WAIT the block is ready. The transition ACCEPT (in_valid high while in WAIT) loads the result registers and moves to SHOW. In SHOW the result is presented for exactly one cycle with in_ready low. The transition RETIRE then returns unconditionally to WAIT.

Top module: `fp64_cmp_flags_unit`

## Requirements
- R1: in_ready is high exactly in WAIT. An input is accepted when in_valid and in_ready are both high at a rising edge. out_valid is high for exactly the one cycle after acceptance, and in_ready is low during that cycle.
- R2: A NaN is a value with exponent field [62:52] all ones and a nonzero fraction [51:0]. If either operand is a NaN, the written condition bits are zero=1, parity=1, carry=1.
- R3: For ordered operands the written condition bits {zero,parity,carry} are 000 for greater-than (operand A above B), 001 for less-than and 100 for equal.
- R4: Positive and negative zero are equal. Other non-NaN values, including infinities and subnormals, are ordered by sign first and then by magnitude, with the magnitude order reversed for negative values.
- R5: out_of, out_sf and out_af are always 0.
- R6: With in_ordered=0, out_inv is 1 only when at least one operand is a signaling NaN, meaning a NaN whose fraction bit 51 is 0.
- R7: With in_ordered=1, out_inv is 1 when at least one operand is a NaN of either kind.
- R8: out_den is 1 when either operand has exponent field 0 and a nonzero fraction.
- R9: out_flag_we is 1 in the result cycle unless out_inv is set with in_mask_inv=0, or out_den is set with in_mask_den=0. When it is 0, zero, parity and carry keep their previous values.
- R10: Bits above bit 63 of each operand word have no effect on any result.
- R11: During reset the machine is in WAIT (in_ready=1), and out_valid, out_flag_we, the condition bits and both status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request carries a compare |
| in_ready | output | 1 | Unit can accept a request |
| in_op_a | input | OPW | First operand word, low 64 bits used |
| in_op_b | input | OPW | Second operand word, low 64 bits used |
| in_ordered | input | 1 | 1: any NaN invalid; 0: only signaling NaN invalid |
| in_mask_inv | input | 1 | Invalid-operation masked |
| in_mask_den | input | 1 | Denormal-operand masked |
| out_valid | output | 1 | Result cycle |
| out_zf | output | 1 | Zero condition bit |
| out_pf | output | 1 | Parity condition bit |
| out_cf | output | 1 | Carry condition bit |
| out_of | output | 1 | Overflow bit, always 0 |
| out_sf | output | 1 | Sign bit, always 0 |
| out_af | output | 1 | Auxiliary-carry bit, always 0 |
| out_inv | output | 1 | Invalid-operation status |
| out_den | output | 1 | Denormal-operand status |
| out_flag_we | output | 1 | Condition bits were written this cycle |

## Verification
Every result is due in the single cycle after the accepting edge. That covers out_valid, the condition bits, both status bits and the write-enable. The bench samples them on the falling edge after that accepting edge, then checks one cycle later that out_valid and the write-enable have dropped and in_ready has returned. A behavioural model keeps the last written condition bits. Each expected value comes from real-number comparison of the decoded operands, with NaNs screened by their bits. This makes a suppressed write visible as unchanged bits at the ports.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
    localparam int FP_W   = 64;
    localparam int EXP_W  = 11;
    localparam int FRAC_W = FP_W - EXP_W - 1;
    localparam int MAG_W  = FP_W - 1;

    typedef enum logic [1:0] {
        REL_GT = 2'd0,
        REL_LT = 2'd1,
        REL_EQ = 2'd2,
        REL_UN = 2'd3
    } rel_e;

    typedef enum logic {
        ST_WAIT = 1'b0,
        ST_SHOW = 1'b1
    } st_e;
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
    import fcmp_pkg::*;
(
    input  logic [FP_W-1:0]  word,
    output logic             is_nan,
    output logic             is_snan,
    output logic             is_zero,
    output logic             is_sub,
    output logic             sign,
    output logic [MAG_W-1:0] mag
);
    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;
    logic              exp_max, exp_min, frac_nz;

    always_comb begin
        expo    = word[FP_W-2 -: EXP_W];
        frac    = word[FRAC_W-1:0];
        exp_max = &expo;
        exp_min = ~|expo;
        frac_nz = |frac;
        is_nan  = exp_max & frac_nz;
        is_snan = is_nan & ~frac[FRAC_W-1];
        is_zero = exp_min & ~frac_nz;
        is_sub  = exp_min & frac_nz;
        sign    = word[FP_W-1];
        mag     = word[MAG_W-1:0];
    end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
    import fcmp_pkg::*;
(
    input  logic             a_nan,
    input  logic             b_nan,
    input  logic             a_zero,
    input  logic             b_zero,
    input  logic             a_sign,
    input  logic             b_sign,
    input  logic [MAG_W-1:0] a_mag,
    input  logic [MAG_W-1:0] b_mag,
    output rel_e             rel
);
    always_comb begin
        if (a_nan || b_nan)
            rel = REL_UN;
        else if (a_zero && b_zero)
            rel = REL_EQ;
        else if (a_sign != b_sign)
            rel = a_sign ? REL_LT : REL_GT;
        else if (a_mag == b_mag)
            rel = REL_EQ;
        else if ((a_mag > b_mag) ^ a_sign)
            rel = REL_GT;
        else
            rel = REL_LT;
    end
endmodule

// File: rtl/fcmp_ctrl.sv
module fcmp_ctrl
    import fcmp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic in_ready,
    input  rel_e rel,
    input  logic any_nan,
    input  logic any_snan,
    input  logic any_sub,
    input  logic in_ordered,
    input  logic in_mask_inv,
    input  logic in_mask_den,
    output logic out_valid,
    output logic out_zf,
    output logic out_pf,
    output logic out_cf,
    output logic out_inv,
    output logic out_den,
    output logic out_flag_we
);
    st_e  state, state_nx;
    logic accept, inv_n, den_n, we_n;
    logic mode_q, mask_inv_q, mask_den_q;
    logic [2:0] code_n;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_WAIT;
        else        state <= state_nx;
    end

    // transitions ACCEPT and RETIRE
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_WAIT: if (in_valid) state_nx = ST_SHOW;
            ST_SHOW: state_nx = ST_WAIT;
        endcase
    end

    // state-decoded handshake outputs
    always_comb begin
        unique case (state)
            ST_WAIT: begin in_ready = 1'b1; out_valid = 1'b0; end
            ST_SHOW: begin in_ready = 1'b0; out_valid = 1'b1; end
        endcase
    end

    always_comb begin
        accept = in_valid && in_ready;
        inv_n  = in_ordered ? any_nan : any_snan;
        den_n  = any_sub;
        we_n   = !((inv_n && !in_mask_inv) || (den_n && !in_mask_den));
        unique case (rel)
            REL_GT: code_n = 3'b000;
            REL_LT: code_n = 3'b001;
            REL_EQ: code_n = 3'b100;
            REL_UN: code_n = 3'b111;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {out_zf, out_pf, out_cf} <= 3'b000;
            out_inv     <= 1'b0;
            out_den     <= 1'b0;
            out_flag_we <= 1'b0;
            mode_q      <= 1'b0;
            mask_inv_q  <= 1'b0;
            mask_den_q  <= 1'b0;
        end else if (accept) begin
            if (we_n) {out_zf, out_pf, out_cf} <= code_n;
            out_inv     <= inv_n;
            out_den     <= den_n;
            out_flag_we <= we_n;
            mode_q      <= in_ordered;
            mask_inv_q  <= in_mask_inv;
            mask_den_q  <= in_mask_den;
        end else begin
            out_flag_we <= 1'b0;
        end
    end

    // R1
    accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);
    // R1
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
    // R1
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);
    // R9
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_flag_we |-> $stable({out_zf, out_pf, out_cf}));
    // R9
    we_in_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_flag_we |-> out_valid);
    // R9
    we_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_flag_we |-> ((!out_inv || mask_inv_q) && (!out_den || mask_den_q)));
    // R2
    unordered_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_pf |-> (out_zf && out_cf));
    // R7
    ordered_nan_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_flag_we && out_pf && mode_q) |-> out_inv);
endmodule

// File: rtl/fp64_cmp_flags_unit.sv
module fp64_cmp_flags_unit
    import fcmp_pkg::*;
#(
    parameter int OPW = 128
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    output logic           in_ready,
    input  logic [OPW-1:0] in_op_a,
    input  logic [OPW-1:0] in_op_b,
    input  logic           in_ordered,
    input  logic           in_mask_inv,
    input  logic           in_mask_den,
    output logic           out_valid,
    output logic           out_zf,
    output logic           out_pf,
    output logic           out_cf,
    output logic           out_of,
    output logic           out_sf,
    output logic           out_af,
    output logic           out_inv,
    output logic           out_den,
    output logic           out_flag_we
);
    localparam int N_OPS = 2;
    localparam int HI_W  = OPW - FP_W;

    logic [N_OPS-1:0][FP_W-1:0]  low_w;
    logic [N_OPS-1:0]            nan_v, snan_v, zero_v, sub_v, sign_v;
    logic [N_OPS-1:0][MAG_W-1:0] mag_v;
    rel_e                        rel;

    assign low_w[0] = in_op_a[FP_W-1:0];
    assign low_w[1] = in_op_b[FP_W-1:0];

    generate
        if (HI_W > 0) begin : g_hi
            logic hi_unused;
            assign hi_unused = ^{in_op_a[OPW-1:FP_W], in_op_b[OPW-1:FP_W]};
        end
        for (genvar g = 0; g < N_OPS; g++) begin : g_cls
            fcmp_classify u_cls (
                .word    (low_w[g]),
                .is_nan  (nan_v[g]),
                .is_snan (snan_v[g]),
                .is_zero (zero_v[g]),
                .is_sub  (sub_v[g]),
                .sign    (sign_v[g]),
                .mag     (mag_v[g])
            );
        end
    endgenerate

    fcmp_order u_order (
        .a_nan  (nan_v[0]),  .b_nan  (nan_v[1]),
        .a_zero (zero_v[0]), .b_zero (zero_v[1]),
        .a_sign (sign_v[0]), .b_sign (sign_v[1]),
        .a_mag  (mag_v[0]),  .b_mag  (mag_v[1]),
        .rel    (rel)
    );

    fcmp_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .rel         (rel),
        .any_nan     (|nan_v),
        .any_snan    (|snan_v),
        .any_sub     (|sub_v),
        .in_ordered  (in_ordered),
        .in_mask_inv (in_mask_inv),
        .in_mask_den (in_mask_den),
        .out_valid   (out_valid),
        .out_zf      (out_zf),
        .out_pf      (out_pf),
        .out_cf      (out_cf),
        .out_inv     (out_inv),
        .out_den     (out_den),
        .out_flag_we (out_flag_we)
    );

    assign out_of = 1'b0;
    assign out_sf = 1'b0;
    assign out_af = 1'b0;
endmodule

// File: tb/fp64_cmp_flags_unit_test.sv
module fp64_cmp_flags_unit_test;
    localparam int OPW = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_ordered = 1'b0, in_mask_inv = 1'b0, in_mask_den = 1'b0;
    logic [OPW-1:0] in_op_a = '0, in_op_b = '0;
    logic in_ready, out_valid, out_zf, out_pf, out_cf, out_of, out_sf, out_af;
    logic out_inv, out_den, out_flag_we;

    int n_run = 0, n_fail = 0;
    bit done = 0;
    logic [2:0] model_flags = 3'b000;
    logic [63:0] vals [13];

    always #2 clk = ~clk;

    fp64_cmp_flags_unit #(.OPW(OPW)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_op_a(in_op_a), .in_op_b(in_op_b), .in_ordered(in_ordered),
        .in_mask_inv(in_mask_inv), .in_mask_den(in_mask_den),
        .out_valid(out_valid), .out_zf(out_zf), .out_pf(out_pf), .out_cf(out_cf),
        .out_of(out_of), .out_sf(out_sf), .out_af(out_af),
        .out_inv(out_inv), .out_den(out_den), .out_flag_we(out_flag_we)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit is_nan(input logic [63:0] v);
        return (v[62:52] == 11'h7FF) && (v[51:0] != 0);
    endfunction
    function automatic bit is_snan(input logic [63:0] v);
        return is_nan(v) && !v[51];
    endfunction
    function automatic bit is_sub(input logic [63:0] v);
        return (v[62:52] == 0) && (v[51:0] != 0);
    endfunction

    function automatic logic [2:0] ref_code(input logic [63:0] a, input logic [63:0] b);
        real ra, rb;
        if (is_nan(a) || is_nan(b)) return 3'b111;
        ra = $bitstoreal(a);
        rb = $bitstoreal(b);
        if (ra < rb) return 3'b001;
        if (ra > rb) return 3'b000;
        return 3'b100;
    endfunction

    task automatic run(input logic [63:0] a, input logic [63:0] b, input logic ord,
                       input logic mi, input logic md,
                       input logic [63:0] ha, input logic [63:0] hb, input string tag);
        logic [2:0] code;
        logic inv, den, we;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_op_a = {ha, a}; in_op_b = {hb, b};
        in_ordered = ord; in_mask_inv = mi; in_mask_den = md;
        in_valid = 1'b1;
        code = ref_code(a, b);
        inv  = ord ? (is_nan(a) || is_nan(b)) : (is_snan(a) || is_snan(b));
        den  = is_sub(a) || is_sub(b);
        we   = !((inv && !mi) || (den && !md));
        if (we) model_flags = code;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check({"R1 valid ", tag}, 64'(out_valid), 64'd1);
        check({"R1 ready low ", tag}, 64'(in_ready), 64'd0);
        check({"R2 R3 R4 R9 flags ", tag}, 64'({out_zf, out_pf, out_cf}), 64'(model_flags));
        check({ord ? "R7 inv " : "R6 inv ", tag}, 64'(out_inv), 64'(inv));
        check({"R8 den ", tag}, 64'(out_den), 64'(den));
        check({"R9 we ", tag}, 64'(out_flag_we), 64'(we));
        check({"R5 zeros ", tag}, 64'({out_of, out_sf, out_af}), 64'd0);
        @(posedge clk);
        @(negedge clk);
        check({"R1 retire ", tag}, 64'({out_valid, out_flag_we, in_ready}), 64'b001);
    endtask

    initial begin
        int wd = 0;
        while (!done && wd < 150000) begin
            @(posedge clk);
            wd++;
        end
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        vals[0]  = 64'h3FF0000000000000; // +1
        vals[1]  = 64'h4000000000000000; // +2
        vals[2]  = 64'hBFF0000000000000; // -1
        vals[3]  = 64'hC000000000000000; // -2
        vals[4]  = 64'h0000000000000000; // +0
        vals[5]  = 64'h8000000000000000; // -0
        vals[6]  = 64'h7FF0000000000000; // +inf
        vals[7]  = 64'hFFF0000000000000; // -inf
        vals[8]  = 64'h7FF8000000000000; // quiet NaN
        vals[9]  = 64'h7FF0000000000001; // signaling NaN
        vals[10] = 64'h0000000000000001; // min subnormal
        vals[11] = 64'h0000000000000002; // subnormal
        vals[12] = 64'h8000000000000001; // negative subnormal

        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 ready in reset", 64'(in_ready), 64'd1);
        check("R11 outputs in reset",
              64'({out_valid, out_flag_we, out_zf, out_pf, out_cf, out_inv, out_den}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 idle after reset", 64'({out_valid, in_ready}), 64'b01);

        // R4 signed zeros, R10 upper-bit noise
        run(vals[4], vals[5], 1'b0, 1'b1, 1'b1, 64'h0, 64'h0, "R4 pz-nz");
        run(vals[0], vals[0], 1'b0, 1'b1, 1'b1, '1, 64'h0, "R10 hi noise eq");
        run(vals[0], vals[1], 1'b0, 1'b1, 1'b1, 64'h0, 64'hFFFF0000AAAA5555, "R10 hi noise lt");
        // R9 suppressed write keeps previous lt code
        run(vals[9], vals[0], 1'b0, 1'b0, 1'b1, 64'h0, 64'h0, "R9 snan unmasked");
        run(vals[10], vals[0], 1'b0, 1'b1, 1'b0, 64'h0, 64'h0, "R9 den unmasked");

        for (int m = 0; m < 2; m++) begin
            for (int i = 0; i < 13; i++) begin
                for (int j = 0; j < 13; j++) begin
                    run(vals[i], vals[j], m[0], 1'((i + j) % 2), 1'((i * j) % 3 != 0),
                        {32'hA5A5F00D ^ 32'(i), 32'(j)}, {32'(m), 32'hC3C3_0001 ^ 32'(j)},
                        $sformatf("m%0d i%0d j%0d", m, i, j));
                end
            end
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule